// File: doc/BRIEF.md
# Execute-Stage Operand Bypass Selector

This block picks, for each of the two ALU operands of a five-stage in-order pipeline, where the execute stage should take its value from. The choices are the register-file read captured at decode, the result sitting in the EX/MEM register, or the value being written back from MEM/WB. It compares the operand source register numbers held in ID/EX against the destination number and write flag of the two older instructions ahead of it. When both older instructions produce the same register, the nearer one in EX/MEM is chosen.

A second, independent path serves the decode stage. When write-back writes a register in the same cycle that decode reads it, the block raises a per-source flag so the write-back value replaces the stale register-file output. Register zero is hard-wired, so neither path ever bypasses for it. All outputs are purely combinational. The datapath multiplexers and the register file are outside the block.

Top module: `operand_bypass_unit`

## Requirements
- R1: Each operand select uses the code 2'b00 for the register-file value, 2'b10 for the EX/MEM result and 2'b01 for the MEM/WB value. The code 2'b11 never appears.
- R2: Operand A select is 2'b10 when the EX/MEM write flag is high, the EX/MEM destination is nonzero, and the ID/EX source A equals that destination.
- R3: Operand B is decided by the same rules as operand A, using source B, and independently of operand A. The two operands may be served from different stages at the same time.
- R4: An operand select is 2'b01 when the MEM/WB write flag is high, the MEM/WB destination is nonzero, the operand's source equals that destination, and the condition of R2 for that operand is false.
- R5: When EX/MEM and MEM/WB both hold a qualifying write to an operand's source, that operand selects EX/MEM (2'b10).
- R6: A source register number of 0 never causes a bypass, on either path, even when a write flag is set with destination 0.
- R7: A stage whose write flag is low never causes a bypass, whatever its destination number is.
- R8: The decode bypass flag for a source is 1 exactly when the write-back flag is high, the write-back destination is nonzero, and that decode source equals the write-back destination. Each source has its own flag.
- R9: Every output follows its inputs within the same evaluation, with no clock edge in between.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| ex_src_a | input | REG_W | ID/EX source register for operand A |
| ex_src_b | input | REG_W | ID/EX source register for operand B |
| exm_rd | input | REG_W | EX/MEM destination register |
| exm_we | input | 1 | EX/MEM register write flag |
| wb_rd | input | REG_W | MEM/WB destination register |
| wb_we | input | 1 | MEM/WB register write flag |
| id_src_a | input | REG_W | Decode-stage first source register |
| id_src_b | input | REG_W | Decode-stage second source register |
| sel_a | output | 2 | Operand A source select |
| sel_b | output | 2 | Operand B source select |
| id_byp_a | output | 1 | Use the write-back value for the first decode source |
| id_byp_b | output | 1 | Use the write-back value for the second decode source |

## Verification
The bench builds the block with its default register-number width of 5 bits, which matches a 32-entry register file. Most random register numbers are drawn from 0 to 3 so that matches, double producers and destination zero come up often. The rest are drawn over the full 5-bit range, which tests the comparison on upper bits where a truncated compare would wrongly match.

// File: rtl/obu_pkg.sv
package obu_pkg;
    // Operand source select codes; values are fixed by the datapath mux
    typedef enum logic [1:0] {
        BYP_RF  = 2'b00,
        BYP_WB  = 2'b01,
        BYP_EXM = 2'b10
    } byp_sel_e;

    localparam int unsigned NUM_EX_SRC = 2;
    localparam int unsigned NUM_ID_SRC = 2;
endpackage

// File: rtl/obu_hit.sv
// Qualified producer match: a live write to a nonzero register equal to src
module obu_hit #(
    parameter int unsigned REG_W = 5
) (
    input  logic             we,
    input  logic [REG_W-1:0] dst,
    input  logic [REG_W-1:0] src,
    output logic             hit
);
    logic dst_live;

    always_comb begin
        dst_live = we && (dst != '0);
        hit      = dst_live && (src == dst);
    end
endmodule

// File: rtl/obu_ex_select.sv
// Per-operand execute-stage source choice, nearer producer first
module obu_ex_select
    import obu_pkg::*;
#(
    parameter int unsigned REG_W = 5
) (
    input  logic [REG_W-1:0] src,
    input  logic             exm_we,
    input  logic [REG_W-1:0] exm_rd,
    input  logic             wb_we,
    input  logic [REG_W-1:0] wb_rd,
    output byp_sel_e         sel
);
    logic exm_hit;
    logic wb_hit;

    obu_hit #(.REG_W(REG_W)) u_exm_hit (
        .we  (exm_we),
        .dst (exm_rd),
        .src (src),
        .hit (exm_hit)
    );

    obu_hit #(.REG_W(REG_W)) u_wb_hit (
        .we  (wb_we),
        .dst (wb_rd),
        .src (src),
        .hit (wb_hit)
    );

    always_comb begin
        unique casez ({exm_hit, wb_hit})
            2'b1?:   sel = BYP_EXM;
            2'b01:   sel = BYP_WB;
            default: sel = BYP_RF;
        endcase
    end
endmodule

// File: rtl/obu_id_bypass.sv
// Decode-stage register-file bypass for a same-cycle write and read
module obu_id_bypass #(
    parameter int unsigned REG_W = 5
) (
    input  logic [REG_W-1:0] src,
    input  logic             wb_we,
    input  logic [REG_W-1:0] wb_rd,
    output logic             use_wb
);
    obu_hit #(.REG_W(REG_W)) u_hit (
        .we  (wb_we),
        .dst (wb_rd),
        .src (src),
        .hit (use_wb)
    );
endmodule

// File: rtl/operand_bypass_unit.sv
module operand_bypass_unit
    import obu_pkg::*;
#(
    parameter int unsigned REG_W = 5
) (
    input  logic [REG_W-1:0] ex_src_a,
    input  logic [REG_W-1:0] ex_src_b,
    input  logic [REG_W-1:0] exm_rd,
    input  logic             exm_we,
    input  logic [REG_W-1:0] wb_rd,
    input  logic             wb_we,
    input  logic [REG_W-1:0] id_src_a,
    input  logic [REG_W-1:0] id_src_b,
    output logic [1:0]       sel_a,
    output logic [1:0]       sel_b,
    output logic             id_byp_a,
    output logic             id_byp_b
);
    logic [REG_W-1:0] ex_src [NUM_EX_SRC];
    byp_sel_e         ex_sel [NUM_EX_SRC];
    logic [REG_W-1:0] id_src [NUM_ID_SRC];
    logic             id_use [NUM_ID_SRC];

    always_comb begin
        ex_src[0] = ex_src_a;
        ex_src[1] = ex_src_b;
        id_src[0] = id_src_a;
        id_src[1] = id_src_b;
    end

    for (genvar i = 0; i < NUM_EX_SRC; i++) begin : g_ex
        obu_ex_select #(.REG_W(REG_W)) u_sel (
            .src    (ex_src[i]),
            .exm_we (exm_we),
            .exm_rd (exm_rd),
            .wb_we  (wb_we),
            .wb_rd  (wb_rd),
            .sel    (ex_sel[i])
        );
    end

    for (genvar j = 0; j < NUM_ID_SRC; j++) begin : g_id
        obu_id_bypass #(.REG_W(REG_W)) u_byp (
            .src    (id_src[j]),
            .wb_we  (wb_we),
            .wb_rd  (wb_rd),
            .use_wb (id_use[j])
        );
    end

    always_comb begin
        sel_a    = ex_sel[0];
        sel_b    = ex_sel[1];
        id_byp_a = id_use[0];
        id_byp_b = id_use[1];
    end
endmodule

// File: rtl/operand_bypass_unit_chk.sv
module operand_bypass_unit_chk #(
    parameter int unsigned REG_W = 5
) (
    input logic [REG_W-1:0] ex_src_a,
    input logic [REG_W-1:0] ex_src_b,
    input logic [REG_W-1:0] exm_rd,
    input logic             exm_we,
    input logic [REG_W-1:0] wb_rd,
    input logic             wb_we,
    input logic [REG_W-1:0] id_src_a,
    input logic [REG_W-1:0] id_src_b,
    input logic [1:0]       sel_a,
    input logic [1:0]       sel_b,
    input logic             id_byp_a,
    input logic             id_byp_b
);
    always_comb begin
        assert_sel_code_R1: assert (sel_a != 2'b11 && sel_b != 2'b11);
        assert_exm_src_a_R2: assert (sel_a != 2'b10 ||
            (exm_we && exm_rd != '0 && ex_src_a == exm_rd));
        assert_exm_src_b_R3: assert (sel_b != 2'b10 ||
            (exm_we && exm_rd != '0 && ex_src_b == exm_rd));
        assert_wb_src_R4: assert ((sel_a != 2'b01 || (wb_we && ex_src_a == wb_rd)) &&
                                  (sel_b != 2'b01 || (wb_we && ex_src_b == wb_rd)));
        assert_near_wins_R5: assert (
            !(exm_we && exm_rd != '0 && ex_src_a == exm_rd) || sel_a == 2'b10);
        assert_reg_zero_R6: assert ((ex_src_a != '0 || sel_a == 2'b00) &&
                                    (ex_src_b != '0 || sel_b == 2'b00) &&
                                    (id_src_a != '0 || !id_byp_a) &&
                                    (id_src_b != '0 || !id_byp_b));
        assert_no_write_R7: assert (wb_we || (!id_byp_a && !id_byp_b &&
                                    sel_a != 2'b01 && sel_b != 2'b01));
        assert_id_match_R8: assert ((!id_byp_a || id_src_a == wb_rd) &&
                                    (!id_byp_b || id_src_b == wb_rd));
    end
endmodule

bind operand_bypass_unit operand_bypass_unit_chk #(.REG_W(REG_W)) u_chk (
    .ex_src_a (ex_src_a),
    .ex_src_b (ex_src_b),
    .exm_rd   (exm_rd),
    .exm_we   (exm_we),
    .wb_rd    (wb_rd),
    .wb_we    (wb_we),
    .id_src_a (id_src_a),
    .id_src_b (id_src_b),
    .sel_a    (sel_a),
    .sel_b    (sel_b),
    .id_byp_a (id_byp_a),
    .id_byp_b (id_byp_b)
);

// File: tb/operand_bypass_unit_bench.sv
module operand_bypass_unit_bench;
    localparam int unsigned REG_W = 5;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2.5 clk = ~clk;

    logic [REG_W-1:0] ex_src_a, ex_src_b, exm_rd, wb_rd, id_src_a, id_src_b;
    logic             exm_we, wb_we;
    logic [1:0]       sel_a, sel_b;
    logic             id_byp_a, id_byp_b;

    int checks = 0;
    int errors = 0;

    operand_bypass_unit #(.REG_W(REG_W)) u_operand_bypass_unit (
        .ex_src_a (ex_src_a),
        .ex_src_b (ex_src_b),
        .exm_rd   (exm_rd),
        .exm_we   (exm_we),
        .wb_rd    (wb_rd),
        .wb_we    (wb_we),
        .id_src_a (id_src_a),
        .id_src_b (id_src_b),
        .sel_a    (sel_a),
        .sel_b    (sel_b),
        .id_byp_a (id_byp_a),
        .id_byp_b (id_byp_b)
    );

    function automatic logic [1:0] want_sel(input logic [REG_W-1:0] s,
                                            input logic ew, input logic [REG_W-1:0] er,
                                            input logic ww, input logic [REG_W-1:0] wr);
        if (ew && er != 0 && s == er) return 2'b10;
        if (ww && wr != 0 && s == wr) return 2'b01;
        return 2'b00;
    endfunction

    function automatic logic want_id(input logic [REG_W-1:0] s,
                                     input logic ww, input logic [REG_W-1:0] wr);
        return ww && wr != 0 && s == wr;
    endfunction

    task automatic check(input string req, input logic [1:0] act, input logic [1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%b expected=%b (srcA=%0d srcB=%0d exm=%0d/%b wb=%0d/%b idA=%0d idB=%0d)",
                     req, act, exp, ex_src_a, ex_src_b, exm_rd, exm_we, wb_rd, wb_we,
                     id_src_a, id_src_b);
        end
    endtask

    task automatic apply(input logic [REG_W-1:0] sa, input logic [REG_W-1:0] sb,
                         input logic ew, input logic [REG_W-1:0] er,
                         input logic ww, input logic [REG_W-1:0] wr,
                         input logic [REG_W-1:0] ia, input logic [REG_W-1:0] ib);
        @(negedge clk);
        ex_src_a = sa; ex_src_b = sb; exm_we = ew; exm_rd = er;
        wb_we = ww; wb_rd = wr; id_src_a = ia; id_src_b = ib;
        #1;
    endtask

    task automatic check_all(input string req);
        check({req, " sel_a"}, sel_a, want_sel(ex_src_a, exm_we, exm_rd, wb_we, wb_rd));
        check({req, " sel_b"}, sel_b, want_sel(ex_src_b, exm_we, exm_rd, wb_we, wb_rd));
        check({req, " id_byp_a"}, {1'b0, id_byp_a}, {1'b0, want_id(id_src_a, wb_we, wb_rd)});
        check({req, " id_byp_b"}, {1'b0, id_byp_b}, {1'b0, want_id(id_src_b, wb_we, wb_rd)});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        ex_src_a = '0; ex_src_b = '0; exm_rd = '0; wb_rd = '0;
        exm_we = 1'b0; wb_we = 1'b0; id_src_a = '0; id_src_b = '0;
        repeat (4) @(posedge clk);
        #1;
        // reset state: idle pipeline selects register file everywhere (R1)
        check("R1 reset sel_a", sel_a, 2'b00);
        check("R1 reset sel_b", sel_b, 2'b00);
        check("R8 reset id", {id_byp_a, id_byp_b}, 2'b00);
        rst = 1'b0;

        // R2: EX/MEM match on operand A only
        apply(5'd7, 5'd3, 1'b1, 5'd7, 1'b0, 5'd0, 5'd1, 5'd2);
        check("R2 exm to A", sel_a, 2'b10);
        check("R3 B untouched", sel_b, 2'b00);
        // R3: EX/MEM match on operand B only
        apply(5'd4, 5'd9, 1'b1, 5'd9, 1'b0, 5'd9, 5'd1, 5'd2);
        check("R3 exm to B", sel_b, 2'b10);
        check("R2 A untouched", sel_a, 2'b00);
        // R4: MEM/WB match
        apply(5'd12, 5'd5, 1'b1, 5'd6, 1'b1, 5'd12, 5'd0, 5'd0);
        check("R4 wb to A", sel_a, 2'b01);
        // R5: both stages produce same register
        apply(5'd8, 5'd8, 1'b1, 5'd8, 1'b1, 5'd8, 5'd0, 5'd0);
        check("R5 near wins A", sel_a, 2'b10);
        check("R5 near wins B", sel_b, 2'b10);
        // R3: operands served from different stages
        apply(5'd10, 5'd11, 1'b1, 5'd11, 1'b1, 5'd10, 5'd10, 5'd11);
        check("R3 A from wb", sel_a, 2'b01);
        check("R3 B from exm", sel_b, 2'b10);
        check("R8 id A", {1'b0, id_byp_a}, 2'b01);
        check("R8 id B", {1'b0, id_byp_b}, 2'b00);
        // R6: destination zero with write flags set
        apply(5'd0, 5'd0, 1'b1, 5'd0, 1'b1, 5'd0, 5'd0, 5'd0);
        check("R6 zero A", sel_a, 2'b00);
        check("R6 zero B", sel_b, 2'b00);
        check("R6 zero id", {id_byp_a, id_byp_b}, 2'b00);
        // R6: EX/MEM zero must not mask a MEM/WB hit on a real register
        apply(5'd0, 5'd3, 1'b1, 5'd0, 1'b1, 5'd3, 5'd3, 5'd0);
        check("R6 exm zero wb B", sel_b, 2'b01);
        // R7: write flags low
        apply(5'd6, 5'd6, 1'b0, 5'd6, 1'b0, 5'd6, 5'd6, 5'd6);
        check("R7 off A", sel_a, 2'b00);
        check("R7 off B", sel_b, 2'b00);
        check("R7 off id", {id_byp_a, id_byp_b}, 2'b00);
        // R7: EX/MEM off, MEM/WB on falls through to wb
        apply(5'd6, 5'd2, 1'b0, 5'd6, 1'b1, 5'd6, 5'd6, 5'd6);
        check("R7 exm off A", sel_a, 2'b01);
        check("R8 both id", {id_byp_a, id_byp_b}, 2'b11);
        // upper-bit compare: 17 vs 1 differ only in bit 4
        apply(5'd17, 5'd1, 1'b1, 5'd1, 1'b1, 5'd17, 5'd1, 5'd17);
        check("R2 upper bits A", sel_a, 2'b01);
        check("R3 upper bits B", sel_b, 2'b10);
        // R9: same-evaluation response with no clock edge between
        @(negedge clk);
        exm_we = 1'b1; exm_rd = 5'd20; ex_src_a = 5'd20;
        #0.5;
        check("R9 comb A", sel_a, 2'b10);
        exm_we = 1'b0;
        #0.5;
        check("R9 comb drop", sel_a, want_sel(ex_src_a, 1'b0, 5'd20, wb_we, wb_rd));

        // random mix (R1..R8)
        void'($urandom(32'd1357));
        for (int n = 0; n < 2000; n++) begin
            logic narrow;
            narrow = ($urandom % 4) != 0;
            apply(narrow ? 5'($urandom % 4) : 5'($urandom),
                  narrow ? 5'($urandom % 4) : 5'($urandom),
                  1'($urandom),
                  narrow ? 5'($urandom % 4) : 5'($urandom),
                  1'($urandom),
                  narrow ? 5'($urandom % 4) : 5'($urandom),
                  narrow ? 5'($urandom % 4) : 5'($urandom),
                  narrow ? 5'($urandom % 4) : 5'($urandom));
            check_all("R1-mix R2 R3 R4 R5 R6 R7 R8");
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule